// File: doc/BRIEF.md
# Class-Pair Issue Interlock

This block sits at the issue stage of a single-issue, in-order pipeline. Each cycle it may be offered one instruction, tagged with a class code, a destination register and up to three source register fields. It holds a small record for every register that a recent instruction is still producing. Each record keeps the class of the producer and the number of cycles that have passed since that producer issued. From these it works out how many more cycles the offered instruction has to wait. That wait depends on the producer class and on the way the consumer uses the value. A value that feeds store data is treated apart from one that feeds an arithmetic operand or an address.

Integer and floating-point registers are tracked in two separate scoreboards. The instruction with the largest remaining wait over its sources decides the outcome. While any wait remains, the instruction is held with stall asserted, and a down-counting stall count is shown for checking. When the count reaches zero, the instruction issues and, if it has a destination, its record is refreshed. Branches write nothing. The instruction in the delay slot after a branch is handled like any other instruction, so its issue is never blocked by the branch itself.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register is pending: the first instruction offered issues at once, and with no valid instruction offered both `out_stall` and `out_issue` are low and `out_stall_cnt` is 0.
- R2: Class codes on `in_class`: 0 integer op (reads integer `in_src_a` and `in_src_b`, writes integer `in_dst`); 1 floating-point add (reads floating-point `in_src_a` and `in_src_b`, writes floating-point `in_dst`); 2 load-double (reads integer `in_src_a` as address, writes floating-point `in_dst`); 3 store-double (reads integer `in_src_a` as address and floating-point `in_src_data` as store data); 4 branch (reads integer `in_src_a`). An instruction whose sources are all clear issues in the cycle it is offered.
- R3: A floating-point add consumed by a floating-point add that is offered in the cycle right after the producer issued waits 3 cycles.
- R4: A floating-point add result consumed as store data in the next cycle waits 2 cycles.
- R5: A load-double result consumed by a floating-point add in the next cycle waits 1 cycle. When it is consumed as store data, the wait is 0.
- R6: An integer result consumed by an integer op or as a load/store address waits 0 cycles. When it is consumed by the branch that follows, the wait is 1 cycle.
- R7: The wait is the pair latency minus the cycles elapsed since the producer issued, floored at zero. Cycles with no valid instruction count as elapsed. With several pending sources, the largest wait applies.
- R8: While a wait remains, `out_stall` is high and `out_issue` is low. `out_stall_cnt` equals the remaining wait and falls by one each cycle while the same instruction is held. The instruction issues in the cycle the count is zero.
- R9: A branch writes no scoreboard record, whatever its `in_dst`. The instruction in its delay slot issues with no wait added because of the branch.
- R10: Integer and floating-point register numbers are separate. Source fields that a class does not read are ignored. Class codes 5 to 7 read and write nothing and issue at once.
- R11: The most recently issued producer of a register sets the latency seen by later consumers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_class | input | 3 | Instruction class code (see R2) |
| in_dst | input | 5 | Destination register number |
| in_src_a | input | 5 | First source (operand or address) |
| in_src_b | input | 5 | Second operand source |
| in_src_data | input | 5 | Store-data source register |
| out_issue | output | 1 | The offered instruction issues at the coming edge |
| out_stall | output | 1 | The offered instruction is held |
| out_stall_cnt | output | 2 | Remaining wait cycles of the offered instruction |

## Verification
Dependent pairs are offered back to back for every producer and consumer combination in the latency table. This separates the 3-, 2-, 1- and 0-cycle cases, and it keeps store data apart from address use. Idle cycles inserted between a producer and its consumer show that elapsed time shortens the wait. Two pending sources with different waits show that the maximum is taken, whichever operand slot holds it. Branches with pending destination fields, unread source fields that point at busy registers, unused class codes and rewritten registers show that only the real, newest producers create waits.

// File: rtl/issue_interlock_pkg.sv
package issue_interlock_pkg;

  localparam int MAX_LAT = 3;
  localparam int GAPW    = $clog2(MAX_LAT + 1);

  localparam logic [2:0] CL_INT  = 3'd0;
  localparam logic [2:0] CL_FADD = 3'd1;
  localparam logic [2:0] CL_LDD  = 3'd2;
  localparam logic [2:0] CL_STD  = 3'd3;
  localparam logic [2:0] CL_BR   = 3'd4;

  typedef enum logic [1:0] {
    PR_INT  = 2'd0,
    PR_FADD = 2'd1,
    PR_LDD  = 2'd2
  } prod_e;

  typedef enum logic [2:0] {
    USE_NONE  = 3'd0,
    USE_INT   = 3'd1,
    USE_ADDR  = 3'd2,
    USE_BR    = 3'd3,
    USE_FOP   = 3'd4,
    USE_SDATA = 3'd5
  } use_e;

  function automatic logic [GAPW-1:0] pair_latency(prod_e p, use_e u);
    logic [GAPW-1:0] lat;
    lat = '0;
    unique case (p)
      PR_FADD: begin
        if (u == USE_FOP)   lat = GAPW'(3);
        if (u == USE_SDATA) lat = GAPW'(2);
      end
      PR_LDD: begin
        if (u == USE_FOP)   lat = GAPW'(1);
      end
      PR_INT: begin
        if (u == USE_BR)    lat = GAPW'(1);
      end
      default: lat = '0;
    endcase
    return lat;
  endfunction

endpackage

// File: rtl/ii_scoreboard.sv
module ii_scoreboard
  import issue_interlock_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  prod_e           wr_cls,
  input  logic [IW-1:0]   rd_idx [NRD],
  output logic            rd_hit [NRD],
  output prod_e           rd_cls [NRD],
  output logic [GAPW-1:0] rd_gap [NRD]
);

  localparam logic [GAPW-1:0] GAP_TOP = GAPW'(MAX_LAT);

  logic [NREGS-1:0] valid_q, valid_d;
  prod_e            cls_q [NREGS];
  prod_e            cls_d [NREGS];
  logic [GAPW-1:0]  gap_q [NREGS];
  logic [GAPW-1:0]  gap_d [NREGS];
  logic [NREGS-1:0] upd_en;

  for (genvar i = 0; i < NREGS; i++) begin : g_entry
    logic wr_hit;
    assign wr_hit = wr_en && (wr_idx == IW'(i));

    always_comb begin
      if (wr_hit) begin
        valid_d[i] = 1'b1;
        cls_d[i]   = wr_cls;
        gap_d[i]   = '0;
      end else begin
        valid_d[i] = valid_q[i];
        cls_d[i]   = cls_q[i];
        gap_d[i]   = (gap_q[i] == GAP_TOP) ? gap_q[i] : gap_q[i] + 1'b1;
      end
      upd_en[i] = wr_hit || (valid_q[i] && (gap_q[i] != GAP_TOP));
    end

    always_ff @(posedge clk) begin
      if (upd_en[i]) begin
        cls_q[i] <= cls_d[i];
        gap_q[i] <= gap_d[i];
      end
    end

    // an unwritten pending record only ages, never gets younger (R7)
    assert_age_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q[i] && !wr_hit) |=> (valid_q[i] && (gap_q[i] >= $past(gap_q[i]))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_comb begin
    for (int k = 0; k < NRD; k++) begin
      rd_hit[k] = valid_q[rd_idx[k]];
      rd_cls[k] = cls_q[rd_idx[k]];
      rd_gap[k] = gap_q[rd_idx[k]];
    end
  end

endmodule

// File: rtl/ii_need.sv
module ii_need
  import issue_interlock_pkg::*;
(
  input  logic            hit,
  input  prod_e           cls,
  input  logic [GAPW-1:0] gap,
  input  use_e            role,
  output logic [GAPW-1:0] need
);

  logic [GAPW-1:0] lat;

  always_comb begin
    lat = pair_latency(cls, role);
    if (hit && (role != USE_NONE) && (lat > gap)) need = lat - gap;
    else                                          need = '0;
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import issue_interlock_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      in_class,
  input  logic [IW-1:0]   in_dst,
  input  logic [IW-1:0]   in_src_a,
  input  logic [IW-1:0]   in_src_b,
  input  logic [IW-1:0]   in_src_data,
  output logic            out_issue,
  output logic            out_stall,
  output logic [GAPW-1:0] out_stall_cnt
);

  localparam int NINT  = 2;
  localparam int NFP   = 3;
  localparam int NSLOT = NINT + NFP;

  // decoded source roles: slots 0..1 integer file, 2..4 floating-point file
  use_e            role   [NSLOT];
  logic            wr_int, wr_fp;
  prod_e           wr_cls;

  logic [IW-1:0]   int_idx [NINT];
  logic            int_hit [NINT];
  prod_e           int_cls [NINT];
  logic [GAPW-1:0] int_gap [NINT];
  logic [IW-1:0]   fp_idx  [NFP];
  logic            fp_hit  [NFP];
  prod_e           fp_cls  [NFP];
  logic [GAPW-1:0] fp_gap  [NFP];

  logic            s_hit  [NSLOT];
  prod_e           s_cls  [NSLOT];
  logic [GAPW-1:0] s_gap  [NSLOT];
  logic [GAPW-1:0] s_need [NSLOT];
  logic [GAPW-1:0] need_max;

  always_comb begin
    for (int k = 0; k < NSLOT; k++) role[k] = USE_NONE;
    wr_int = 1'b0;
    wr_fp  = 1'b0;
    wr_cls = PR_INT;
    unique case (in_class)
      CL_INT: begin
        role[0] = USE_INT;
        role[1] = USE_INT;
        wr_int  = 1'b1;
        wr_cls  = PR_INT;
      end
      CL_FADD: begin
        role[2] = USE_FOP;
        role[3] = USE_FOP;
        wr_fp   = 1'b1;
        wr_cls  = PR_FADD;
      end
      CL_LDD: begin
        role[0] = USE_ADDR;
        wr_fp   = 1'b1;
        wr_cls  = PR_LDD;
      end
      CL_STD: begin
        role[0] = USE_ADDR;
        role[4] = USE_SDATA;
      end
      CL_BR: begin
        role[0] = USE_BR;
      end
      default: ;
    endcase
  end

  assign int_idx[0] = in_src_a;
  assign int_idx[1] = in_src_b;
  assign fp_idx[0]  = in_src_a;
  assign fp_idx[1]  = in_src_b;
  assign fp_idx[2]  = in_src_data;

  ii_scoreboard #(.NREGS(NREGS), .NRD(NINT)) u_sb_int (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (out_issue && wr_int),
    .wr_idx (in_dst),
    .wr_cls (wr_cls),
    .rd_idx (int_idx),
    .rd_hit (int_hit),
    .rd_cls (int_cls),
    .rd_gap (int_gap)
  );

  ii_scoreboard #(.NREGS(NREGS), .NRD(NFP)) u_sb_fp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (out_issue && wr_fp),
    .wr_idx (in_dst),
    .wr_cls (wr_cls),
    .rd_idx (fp_idx),
    .rd_hit (fp_hit),
    .rd_cls (fp_cls),
    .rd_gap (fp_gap)
  );

  always_comb begin
    for (int k = 0; k < NINT; k++) begin
      s_hit[k] = int_hit[k];
      s_cls[k] = int_cls[k];
      s_gap[k] = int_gap[k];
    end
    for (int k = 0; k < NFP; k++) begin
      s_hit[NINT+k] = fp_hit[k];
      s_cls[NINT+k] = fp_cls[k];
      s_gap[NINT+k] = fp_gap[k];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ii_need u_need (
      .hit  (s_hit[s]),
      .cls  (s_cls[s]),
      .gap  (s_gap[s]),
      .role (role[s]),
      .need (s_need[s])
    );
  end

  always_comb begin
    need_max = '0;
    for (int k = 0; k < NSLOT; k++)
      if (s_need[k] > need_max) need_max = s_need[k];
  end

  assign out_issue     = in_valid && (need_max == '0);
  assign out_stall     = in_valid && (need_max != '0);
  assign out_stall_cnt = in_valid ? need_max : '0;

  // R1: nothing offered, nothing signalled
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!out_stall && !out_issue && (out_stall_cnt == '0)));

  // R8: held and issued never together
  assert_hold_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_stall && out_issue));

  // R8: a held, unchanged instruction counts down by one
  assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |=> (!(in_valid && $stable(in_class) && $stable(in_src_a) &&
                     $stable(in_src_b) && $stable(in_src_data))
                   || (out_stall_cnt == $past(out_stall_cnt) - 1'b1)));

  // R3: back-to-back dependent floating-point adds see the full wait
  assert_fadd_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_issue) && ($past(in_class) == CL_FADD) &&
     in_valid && (in_class == CL_FADD) && (in_src_a == $past(in_dst)))
    |-> (out_stall_cnt == GAPW'(3)));

  // R9: a branch never refreshes a record
  assert_branch_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_issue && (in_class == CL_BR)) |-> (!wr_int && !wr_fp));

endmodule

// File: tb/test_issue_interlock.sv
module test_issue_interlock;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [2:0] in_class;
  logic [4:0] in_dst, in_src_a, in_src_b, in_src_data;
  logic       out_issue, out_stall;
  logic [1:0] out_stall_cnt;

  typedef struct {
    int    stalls;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   fresh  = 0;
  bit   done   = 0;
  event issued_ev;

  issue_interlock i_issue_interlock (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_class      (in_class),
    .in_dst        (in_dst),
    .in_src_a      (in_src_a),
    .in_src_b      (in_src_b),
    .in_src_data   (in_src_data),
    .out_issue     (out_issue),
    .out_stall     (out_stall),
    .out_stall_cnt (out_stall_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input int d, input int a, input int b,
                      input int s, input int exp_stalls, input string req);
    exp_t e;
    @(negedge clk);
    in_valid    = 1'b1;
    in_class    = c;
    in_dst      = 5'(d);
    in_src_a    = 5'(a);
    in_src_b    = 5'(b);
    in_src_data = 5'(s);
    e.stalls    = exp_stalls;
    e.req       = req;
    q.push_back(e);
    fresh = 1'b1;
    @(issued_ev);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: samples between edges, compares against the queued expectation
  initial begin
    int first_cnt;
    int stalls;
    int prev;
    exp_t e;
    first_cnt = 0;
    stalls    = 0;
    prev      = 0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && in_valid) begin
        if (fresh) begin
          fresh     = 1'b0;
          first_cnt = int'(out_stall_cnt);
          stalls    = 0;
        end else begin
          check(int'(out_stall_cnt) == prev - 1, "R8 countdown", int'(out_stall_cnt), prev - 1);
        end
        prev = int'(out_stall_cnt);
        if (out_stall) begin
          stalls++;
          check(!out_issue, "R8 held", int'(out_issue), 0);
        end
        if (out_issue) begin
          if (q.size() == 0) begin
            check(1'b0, "R8 unexpected issue", 1, 0);
          end else begin
            e = q.pop_front();
            check(first_cnt == e.stalls, {e.req, " first count"}, first_cnt, e.stalls);
            check(stalls == e.stalls, {e.req, " stall cycles"}, stalls, e.stalls);
          end
          ->issued_ev;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_class    = 3'd0;
    in_dst      = '0;
    in_src_a    = '0;
    in_src_b    = '0;
    in_src_data = '0;
    repeat (3) @(posedge clk);
    #2;
    check(!out_stall && !out_issue && out_stall_cnt == 0, "R1 reset outputs",
          int'({out_stall, out_issue, out_stall_cnt}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!out_stall && !out_issue, "R1 idle after reset", int'({out_stall, out_issue}), 0);

    // class codes: 0 int, 1 fadd, 2 load, 3 store, 4 branch
    send(3'd1,  1,  2,  3,  0, 0, "R1 clear start");
    send(3'd1,  4,  1,  2,  0, 3, "R3 fadd->fadd");
    send(3'd3,  0,  1,  0,  4, 2, "R4 fadd->store data");
    send(3'd2,  5,  2,  0,  0, 0, "R2 load clear");
    send(3'd1,  6,  5,  0,  0, 1, "R5 load->fadd");
    send(3'd2,  7,  3,  0,  0, 0, "R2 load clear");
    send(3'd3,  0,  3,  0,  7, 0, "R5 load->store data");
    send(3'd0,  4,  1,  2,  0, 0, "R2 int clear");
    send(3'd0,  5,  4,  4,  0, 0, "R6 int->int");
    send(3'd2,  8,  5,  0,  0, 0, "R6 int->address");
    send(3'd0,  6,  1,  1,  0, 0, "R2 int clear");
    send(3'd4,  8,  6,  0,  0, 1, "R6 int->branch");
    send(3'd0,  7,  6,  6,  0, 0, "R9 delay slot");
    send(3'd4,  9,  1,  0,  0, 0, "R9 branch clear");
    send(3'd4,  0,  9,  0,  0, 0, "R9 branch wrote nothing");
    send(3'd1, 10,  2,  3,  0, 0, "R2 fadd clear");
    send(3'd2, 11,  1,  0,  0, 0, "R2 load clear");
    send(3'd1, 12, 11, 10,  0, 2, "R7 max of sources");
    send(3'd1, 22,  2,  3,  0, 0, "R2 fadd clear");
    idle(2);
    send(3'd1, 23, 22,  0,  0, 1, "R7 idle cycles elapse");
    send(3'd1, 24,  2,  3,  0, 0, "R2 fadd clear");
    send(3'd0, 24, 24, 24, 24, 0, "R10 separate files");
    send(3'd1, 27,  2,  3,  0, 0, "R2 fadd clear");
    send(3'd5, 29, 27, 27, 27, 0, "R10 unused class");
    send(3'd1, 30, 29,  0,  0, 0, "R10 unused class no write");
    send(3'd2, 28,  1,  0,  0, 0, "R2 load clear");
    send(3'd1, 28,  0,  0,  0, 0, "R2 fadd clear");
    send(3'd3,  0,  1,  0, 28, 2, "R11 newest producer");
    idle(2);
    check(q.size() == 0, "R8 all issued", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule